// File: doc/BRIEF.md
# DMA Stream Interrupt Flag Bank

This block collects one-cycle event pulses from eight DMA streams and latches them as sticky flags. Each stream has a six-bit flag group, and the groups are packed into two 32-bit status words: one word for the lower four streams and one for the upper four. Software reads the status words through a small register port. It clears individual flags by writing ones to a matching clear word that uses the same bit layout.

The block also drives one interrupt line per stream. A line is raised by that stream's latched flags, gated by the stream's enable inputs. A separate read view returns the flag group of any chosen stream, masked so that only the flags relevant to error and completion handling remain. The transfer engines that produce the event pulses sit outside this block.

Top module: `dsif_flag_bank`

## Requirements
- R1: A synchronous reset clears every flag, so both status words read 0 and every interrupt line is low in the cycle after reset is sampled.
- R2: An event pulse sampled at a clock edge sets its flag, and the flag is visible in the status word from the next cycle on.
- R3: Streams 0 to 3 appear in the low status word (address 0x0) and streams 4 to 7 in the high status word (address 0x4). Inside a word, a stream's group starts at bit 16*s[1] + 6*s[0], so the bases are 0, 6, 16 and 22.
- R4: Within a group, bit 5 is transfer complete, bit 4 is half transfer, bit 3 is transfer error, bit 2 is direct-mode error and bit 0 is FIFO error. Bit 1 always reads 0.
- R5: A write to address 0x8 (low) or 0xC (high) clears each flag whose bit is 1 in the write data. Bits written as 0 leave their flags unchanged.
- R6: Writes to the status addresses 0x0 and 0x4 change no flag.
- R7: When an event and a clear hit the same flag in the same cycle, the flag is set afterwards.
- R8: A stream's interrupt line is the OR of (transfer complete AND its enable), (transfer error AND its enable) and (direct-mode error AND its enable). Half-transfer and FIFO-error flags never raise it.
- R9: Flags are set whatever the enables are, and with all enables low they can still be cleared.
- R10: The stream view returns the group of the stream chosen by the view select, with bits 5, 3, 2 and 0 kept. Bits 4 and 1 read 0.
- R11: With no event and no clear, a flag keeps its value. Reads of 0x8, 0xC and any other unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_tc | input | 8 | Transfer-complete pulse, one per stream |
| ev_ht | input | 8 | Half-transfer pulse, one per stream |
| ev_te | input | 8 | Transfer-error pulse, one per stream |
| ev_dme | input | 8 | Direct-mode-error pulse, one per stream |
| ev_fe | input | 8 | FIFO-error pulse, one per stream |
| en_tc | input | 8 | Transfer-complete interrupt enable per stream |
| en_te | input | 8 | Transfer-error interrupt enable per stream |
| en_dme | input | 8 | Direct-mode-error interrupt enable per stream |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| view_sel | input | 3 | Stream chosen for the masked view |
| view_flags | output | 6 | Masked flag group of the chosen stream |
| irq | output | 8 | Interrupt line per stream |

## Verification
On every cycle, the assertions check the flag update rules inside each stream slice: reset clearing, set-on-event, clear-on-write-one and hold otherwise. They also check that writes to the status addresses leave the words untouched and that the interrupt lines stay low when no enable is set. The bench scenarios are needed to show the irregular packing of the groups into the two words. They also show the priority of an event over a same-cycle clear, the exclusion of half-transfer and FIFO-error flags from the interrupt lines and from the masked view, and the zero reads of the clear addresses.

// File: rtl/dsif_pkg.sv
package dsif_pkg;
   localparam int GRP_W  = 6;
   localparam int B_TC   = 5;
   localparam int B_HT   = 4;
   localparam int B_TE   = 3;
   localparam int B_DME  = 2;
   localparam int B_FE   = 0;
   localparam int HALF_SHIFT = 16;
   localparam int PAIR_SHIFT = 6;
   localparam logic [GRP_W-1:0] VIEW_MASK = 6'b101101;

   // bit base of a stream's group inside its status word
   function automatic int grp_base(input int s);
      return ((s >> 1) & 1) * HALF_SHIFT + (s & 1) * PAIR_SHIFT;
   endfunction
endpackage

// File: rtl/dsif_stream_flags.sv
module dsif_stream_flags
   import dsif_pkg::*;
#(
   parameter int W = GRP_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] ev,
   input  logic [W-1:0] clr,
   output logic [W-1:0] flags
);
   always_ff @(posedge clk) begin
      if (rst) flags <= '0;
      else     flags <= (flags & ~clr) | ev;
   end

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (flags == '0));

   assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
      (ev != '0) |=> ((flags & $past(ev)) == $past(ev)));

   assert_clear_takes_R5: assert property (@(posedge clk) disable iff (rst)
      (clr != '0) |=> ((flags & $past(clr) & ~$past(ev)) == '0));

   assert_flags_hold_R11: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (((flags ^ $past(flags)) & ~($past(ev) | $past(clr))) == '0));
endmodule

// File: rtl/dsif_irq_gate.sv
module dsif_irq_gate
   import dsif_pkg::*;
(
   input  logic [GRP_W-1:0] flags,
   input  logic             en_tc,
   input  logic             en_te,
   input  logic             en_dme,
   output logic             irq
);
   logic unused_flag_bits;
   assign unused_flag_bits = ^{flags[B_HT], flags[1], flags[B_FE]};

   always_comb begin
      irq = (flags[B_TC]  & en_tc)
          | (flags[B_TE]  & en_te)
          | (flags[B_DME] & en_dme);
   end
endmodule

// File: rtl/dsif_read_mux.sv
module dsif_read_mux
   import dsif_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int NUM_STREAMS = 8,
   parameter logic [ADDR_W-1:0] A_STAT_LO = 4'h0,
   parameter logic [ADDR_W-1:0] A_STAT_HI = 4'h4,
   localparam int SEL_W = $clog2(NUM_STREAMS)
) (
   input  logic [DATA_W-1:0]                   stat_lo,
   input  logic [DATA_W-1:0]                   stat_hi,
   input  logic [NUM_STREAMS-1:0][GRP_W-1:0]   grps,
   input  logic [ADDR_W-1:0]                   rd_addr,
   input  logic [SEL_W-1:0]                    view_sel,
   output logic [DATA_W-1:0]                   rd_data,
   output logic [GRP_W-1:0]                    view_flags
);
   always_comb begin
      unique case (rd_addr)
         A_STAT_LO: rd_data = stat_lo;
         A_STAT_HI: rd_data = stat_hi;
         default:   rd_data = '0;
      endcase
      view_flags = grps[view_sel] & VIEW_MASK;
   end
endmodule

// File: rtl/dsif_flag_bank.sv
module dsif_flag_bank
   import dsif_pkg::*;
#(
   parameter int NUM_STREAMS = 8,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   localparam int SEL_W      = $clog2(NUM_STREAMS),
   localparam int HALF       = NUM_STREAMS / 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [NUM_STREAMS-1:0] ev_tc,
   input  logic [NUM_STREAMS-1:0] ev_ht,
   input  logic [NUM_STREAMS-1:0] ev_te,
   input  logic [NUM_STREAMS-1:0] ev_dme,
   input  logic [NUM_STREAMS-1:0] ev_fe,
   input  logic [NUM_STREAMS-1:0] en_tc,
   input  logic [NUM_STREAMS-1:0] en_te,
   input  logic [NUM_STREAMS-1:0] en_dme,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [DATA_W-1:0]      rd_data,
   input  logic [SEL_W-1:0]       view_sel,
   output logic [GRP_W-1:0]       view_flags,
   output logic [NUM_STREAMS-1:0] irq
);
   localparam logic [ADDR_W-1:0] A_STAT_LO = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_STAT_HI = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_CLR_LO  = ADDR_W'(8);
   localparam logic [ADDR_W-1:0] A_CLR_HI  = ADDR_W'(12);

   generate
      if (NUM_STREAMS != 8) begin : g_bad_streams
         $error("dsif_flag_bank: the packed layout needs exactly 8 streams");
      end
      if (DATA_W < HALF_SHIFT + PAIR_SHIFT + GRP_W) begin : g_bad_width
         $error("dsif_flag_bank: DATA_W too narrow for the group layout");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("dsif_flag_bank: ADDR_W must reach offset 0xC");
      end
   endgenerate

   logic [NUM_STREAMS-1:0][GRP_W-1:0] grps;
   logic [DATA_W-1:0] stat_lo, stat_hi;
   logic clr_lo_hit, clr_hi_hit;
   logic unused_wr_bits;

   assign clr_lo_hit     = wr_en && (wr_addr == A_CLR_LO);
   assign clr_hi_hit     = wr_en && (wr_addr == A_CLR_HI);
   assign unused_wr_bits = ^wr_data;

   for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
      localparam int BASE = grp_base(s);
      logic [GRP_W-1:0] ev_grp, clr_grp;

      assign ev_grp = {ev_tc[s], ev_ht[s], ev_te[s], ev_dme[s], 1'b0, ev_fe[s]};

      if (s < HALF) begin : g_low
         assign clr_grp = clr_lo_hit ? wr_data[BASE +: GRP_W] : '0;
      end else begin : g_high
         assign clr_grp = clr_hi_hit ? wr_data[BASE +: GRP_W] : '0;
      end

      dsif_stream_flags #(.W(GRP_W)) u_flags (
         .clk   (clk),
         .rst   (rst),
         .ev    (ev_grp),
         .clr   (clr_grp),
         .flags (grps[s])
      );

      dsif_irq_gate u_irq (
         .flags  (grps[s]),
         .en_tc  (en_tc[s]),
         .en_te  (en_te[s]),
         .en_dme (en_dme[s]),
         .irq    (irq[s])
      );
   end

   always_comb begin
      stat_lo = '0;
      stat_hi = '0;
      for (int s = 0; s < NUM_STREAMS; s++) begin
         if (s < HALF) stat_lo[grp_base(s) +: GRP_W] = grps[s];
         else          stat_hi[grp_base(s) +: GRP_W] = grps[s];
      end
   end

   dsif_read_mux #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .NUM_STREAMS (NUM_STREAMS),
      .A_STAT_LO   (A_STAT_LO),
      .A_STAT_HI   (A_STAT_HI)
   ) u_rd (
      .stat_lo    (stat_lo),
      .stat_hi    (stat_hi),
      .grps       (grps),
      .rd_addr    (rd_addr),
      .view_sel   (view_sel),
      .rd_data    (rd_data),
      .view_flags (view_flags)
   );

   // R6: a write aimed at a status word, with no events, leaves it unchanged
   assert_status_readonly_R6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_addr == A_STAT_LO || wr_addr == A_STAT_HI) &&
       (ev_tc | ev_ht | ev_te | ev_dme | ev_fe) == '0)
      |=> ($stable(stat_lo) && $stable(stat_hi)));

   assert_no_enable_no_irq_R8: assert property (@(posedge clk) disable iff (rst)
      ((en_tc | en_te | en_dme) == '0) |-> (irq == '0));

   assert_clear_addr_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
      (rd_addr == A_CLR_LO || rd_addr == A_CLR_HI) |-> (rd_data == '0));
endmodule

// File: tb/dsif_flag_bank_tb.sv
`timescale 1ns/1ps
module dsif_flag_bank_tb;
   localparam int NS = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NS-1:0] ev_tc = '0, ev_ht = '0, ev_te = '0, ev_dme = '0, ev_fe = '0;
   logic [NS-1:0] en_tc = '0, en_te = '0, en_dme = '0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [3:0]    rd_addr = '0;
   logic [2:0]    view_sel = '0;
   logic [31:0]   rd_data;
   logic [5:0]    view_flags;
   logic [NS-1:0] irq;

   always #4 clk = ~clk;

   dsif_flag_bank u_dut (
      .clk(clk), .rst(rst),
      .ev_tc(ev_tc), .ev_ht(ev_ht), .ev_te(ev_te), .ev_dme(ev_dme), .ev_fe(ev_fe),
      .en_tc(en_tc), .en_te(en_te), .en_dme(en_dme),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .view_sel(view_sel), .view_flags(view_flags), .irq(irq)
   );

   typedef struct {
      int          kind;   // 0 rd_data, 1 view_flags, 2 irq
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sbq[$];
   int n_checks = 0;
   int n_fail   = 0;
   logic [5:0] m_grp [NS];

   function automatic int base_of(input int s);
      return (s % 4 >= 2 ? 16 : 0) + (s % 2 == 1 ? 6 : 0);
   endfunction

   function automatic logic [31:0] model_word(input bit hi);
      logic [31:0] w = '0;
      for (int s = 0; s < 4; s++) begin
         int si = hi ? s + 4 : s;
         w[base_of(s) +: 6] = m_grp[si];
      end
      return w;
   endfunction

   function automatic logic [NS-1:0] model_irq();
      logic [NS-1:0] v;
      for (int s = 0; s < NS; s++)
         v[s] = (m_grp[s][5] & en_tc[s]) | (m_grp[s][3] & en_te[s]) | (m_grp[s][2] & en_dme[s]);
      return v;
   endfunction

   // monitor: pop one expectation per cycle, compare away from the edge
   always @(negedge clk) begin
      if (sbq.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sbq.pop_front();
         case (it.kind)
            0:       act = rd_data;
            1:       act = {26'd0, view_flags};
            default: act = {24'd0, irq};
         endcase
         n_checks++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FIFO check FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
         end
      end
   end

   // one clock of stimulus: event groups per stream plus an optional write
   task automatic drive_cycle(input logic [NS-1:0][5:0] evg, input logic we,
                              input logic [3:0] a, input logic [31:0] d);
      for (int s = 0; s < NS; s++) begin
         ev_tc[s] = evg[s][5]; ev_ht[s] = evg[s][4]; ev_te[s] = evg[s][3];
         ev_dme[s] = evg[s][2]; ev_fe[s] = evg[s][0];
      end
      wr_en = we; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      ev_tc = '0; ev_ht = '0; ev_te = '0; ev_dme = '0; ev_fe = '0;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      for (int s = 0; s < NS; s++) begin
         logic [5:0] c = '0;
         logic [5:0] e = evg[s] & 6'b111101;
         if (we && ((s < 4 && a == 4'h8) || (s >= 4 && a == 4'hC)))
            c = d[base_of(s) +: 6];
         m_grp[s] = (m_grp[s] & ~c) | e;
      end
   endtask

   task automatic pulse(input int s, input logic [5:0] g);
      logic [NS-1:0][5:0] evg = '0;
      evg[s] = g;
      drive_cycle(evg, 1'b0, 4'h0, 32'h0);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      drive_cycle('0, 1'b1, a, d);
   endtask

   task automatic expect_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
      item_t it;
      rd_addr = a;
      it.kind = 0; it.exp = e; it.tag = tag;
      sbq.push_back(it);
      @(posedge clk); #1;
   endtask

   task automatic expect_words(input string tag);
      expect_rd(4'h0, model_word(1'b0), tag);
      expect_rd(4'h4, model_word(1'b1), tag);
   endtask

   task automatic expect_view(input int s, input string tag);
      item_t it;
      view_sel = 3'(s);
      it.kind = 1; it.exp = {26'd0, m_grp[s] & 6'b101101}; it.tag = tag;
      sbq.push_back(it);
      @(posedge clk); #1;
   endtask

   task automatic expect_irq(input string tag);
      item_t it;
      it.kind = 2; it.exp = {24'd0, model_irq()}; it.tag = tag;
      sbq.push_back(it);
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      for (int s = 0; s < NS; s++) m_grp[s] = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("watchdog FAIL R11 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [NS-1:0][5:0] evg;
      @(posedge clk); #1;
      do_reset();

      // R1: reset state
      expect_rd(4'h0, 32'h0, "R1");
      expect_rd(4'h4, 32'h0, "R1");
      expect_irq("R1");

      // R2 R4: stream 0 transfer complete lands at bit 5
      pulse(0, 6'b100000);
      expect_rd(4'h0, 32'h0000_0020, "R2");

      // R3: literal placement of stream 3 half transfer (bit 22+4) and stream 6 FIFO error (bit 16)
      pulse(3, 6'b010000);
      expect_rd(4'h0, 32'h0400_0020, "R3");
      pulse(6, 6'b000001);
      expect_rd(4'h4, 32'h0001_0000, "R3");

      // R3 R4: every stream, distinct patterns, all in one cycle
      for (int s = 0; s < NS; s++) evg[s] = 6'(s * 5 + 3) & 6'b111101;
      drive_cycle(evg, 1'b0, 4'h0, 32'h0);
      expect_words("R3");

      // R4: all five events on stream 5, bit 1 stays zero
      pulse(5, 6'b111111);
      expect_rd(4'h4, model_word(1'b1), "R4");

      // R5: writing zeros has no effect, then clear stream 0 and stream 1 bits
      wr(4'h8, 32'h0);
      expect_words("R5");
      wr(4'h8, 32'h0000_0FFF);
      expect_rd(4'h0, model_word(1'b0), "R5");
      wr(4'hC, 32'h0000_0020 << 16);
      expect_rd(4'h4, model_word(1'b1), "R5");

      // R6: writes to status words change nothing
      wr(4'h0, 32'hFFFF_FFFF);
      wr(4'h4, 32'hFFFF_FFFF);
      expect_words("R6");

      // R11: clear addresses and unmapped addresses read zero
      expect_rd(4'h8, 32'h0, "R11");
      expect_rd(4'hC, 32'h0, "R11");
      expect_rd(4'h2, 32'h0, "R11");

      // R7: event and clear of the same flag in one cycle
      evg = '0; evg[1] = 6'b001000;
      drive_cycle(evg, 1'b1, 4'h8, 32'h0000_0FC0);
      expect_rd(4'h0, model_word(1'b0), "R7");
      if (m_grp[1][3] !== 1'b1) begin n_fail++; $display("model FAIL R7 actual=0 expected=1"); end

      // R9: flags set with enables low, no interrupts
      pulse(2, 6'b101100);
      expect_irq("R9");

      // R8: enables gate the interrupt lines
      en_tc = 8'hFF; en_te = 8'hFF; en_dme = 8'hFF;
      expect_irq("R8");
      wr(4'hC, 32'hFFFF_FFFF);
      wr(4'h8, 32'hFFFF_FFFF);
      pulse(6, 6'b010001);          // half transfer + FIFO error only
      expect_irq("R8");
      en_tc = 8'h00; en_te = 8'h00; en_dme = 8'h04;
      pulse(2, 6'b100000);
      expect_irq("R8");
      pulse(2, 6'b000100);
      expect_irq("R8");

      // R9: clear works with enables low
      en_tc = '0; en_te = '0; en_dme = '0;
      wr(4'h8, 32'h003F_0000);
      expect_rd(4'h0, model_word(1'b0), "R9");

      // R10: masked view of every stream
      for (int s = 0; s < NS; s++) evg[s] = 6'b111101;
      drive_cycle(evg, 1'b0, 4'h0, 32'h0);
      for (int s = 0; s < NS; s++) expect_view(s, "R10");

      // R11: idle cycles keep the flags
      repeat (3) @(posedge clk); #1;
      expect_words("R11");

      // R1: reset in mid run
      do_reset();
      expect_words("R1");

      @(negedge clk);
      @(posedge clk); #1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule